// File: doc/BRIEF.md
# Data Access Fault Classifier

This block inspects every data memory access (load, store or cache operation) together with the outcome of address translation and the attributes of the target segment. It decides whether a data storage fault must be raised. The conditions it looks for are a page fault from the table search after a translation miss, a protection violation, an access to a direct-store segment, and a match against a data address breakpoint. A floating-point load or store to a direct-store segment is routed to this fault, and the block also tells the alignment checker to stand down for that access.

The block produces a one-cycle fault request together with the 0x300 vector offset and a cause vector naming every condition that fired. It captures the faulting effective address in the same cycle as the request. Arbitration against other exception types is outside the block, except for one input that reports an exception of higher priority pending on the same access. Translation itself is done elsewhere.

Top module: `dacc_fault_unit`

## Requirements
- R1: `acc_kind` encodes 2'b00 = load, 2'b01 = store, 2'b10 = cache operation, 2'b11 = no access. With 2'b11 no fault is ever raised, whatever the other inputs hold.
- R2: A fault with cause bit 0 (page) is raised when `xlate_miss` and `walk_page_fault` are both 1 for a load, store or cache operation. `walk_page_fault` has no effect while `xlate_miss` is 0, and a miss without a page fault raises nothing by itself.
- R3: A fault with cause bit 1 (protection) is raised when `prot_violation` is 1 on an access whose translation hit (`xlate_miss` = 0).
- R4: A fault with cause bit 2 (direct-store) is raised for any load or store while `seg_direct_store` is 1. A cache operation to such a segment does not set bit 2.
- R5: When a floating-point load or store (`acc_fp` = 1) raises cause bit 2, `align_veto` is 1 in the cycle of the request. In all other cycles it is 0.
- R6: Cause bit 3 (breakpoint) is set when bits [AW-1:3] of `acc_ea` equal those of `bkpt_ea`, for a load with `bkpt_rd_en` = 1 or a store with `bkpt_wr_en` = 1. Cache operations never match.
- R7: While `hipri_pending` is 1, no fault is raised for that access: `fault_req` stays 0, `fault_cause` stays 0 and `fault_ea` keeps its value.
- R8: A fault is signalled by `fault_req` = 1 for exactly one cycle, in the cycle after the access. In that cycle `fault_cause` holds every matching cause bit and `fault_vec` = 12'h300. In all other cycles `fault_cause` and `fault_vec` are 0.
- R9: `fault_ea` takes the access's effective address in the cycle `fault_req` is 1 and holds it until the next fault.
- R10: After reset, `fault_req`, `fault_cause`, `fault_vec`, `align_veto` and `fault_ea` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_kind | input | 2 | Access type encoding (see R1) |
| acc_fp | input | 1 | Access is a floating-point load or store |
| acc_ea | input | AW | Effective address of the access |
| seg_direct_store | input | 1 | Target segment is direct-store |
| xlate_miss | input | 1 | Translation missed in the buffers |
| walk_page_fault | input | 1 | Table search after the miss found no page |
| prot_violation | input | 1 | Protection check failed |
| bkpt_ea | input | AW | Data breakpoint address |
| bkpt_rd_en | input | 1 | Breakpoint armed for loads |
| bkpt_wr_en | input | 1 | Breakpoint armed for stores |
| hipri_pending | input | 1 | Higher-priority exception pending for this access |
| fault_req | output | 1 | One-cycle data storage fault request |
| fault_vec | output | VEC_W | Vector offset, 0x300 during a request |
| fault_cause | output | 4 | Cause bits: 0 page, 1 protection, 2 direct-store, 3 breakpoint |
| fault_ea | output | AW | Captured faulting effective address |
| align_veto | output | 1 | Suppresses the alignment fault for this access |

## Verification
Because the block keeps almost no state, a wrong condition term or a wrong register shows at the ports on the very next cycle. It appears as a missing or extra `fault_req`, a wrong cause bit, or a stale `fault_ea`. The only state that lives longer is the held address, and a bad hold shows up at the next fault that is expected to leave it alone. A sweep over every combination of access type and condition flags, with three address relations to the breakpoint, exposes each wrong term within one cycle of the input pattern that needs it.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_CACHE = 2'b10,
      ACC_NONE  = 2'b11
   } acc_kind_e;

   localparam int CAUSE_W = 4;
   localparam int C_PAGE  = 0;
   localparam int C_PROT  = 1;
   localparam int C_DSEG  = 2;
   localparam int C_BKPT  = 3;

   typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/dfc_bkpt_match.sv
module dfc_bkpt_match #(
   parameter int AW        = 32,
   parameter int GRAN_LOG2 = 3
) (
   input  logic [AW-1:0] ea,
   input  logic [AW-1:0] bkpt_ea,
   input  logic          is_load,
   input  logic          is_store,
   input  logic          rd_en,
   input  logic          wr_en,
   output logic          hit
);
   localparam int CMP_W = AW - GRAN_LOG2;

   if (GRAN_LOG2 < 0 || GRAN_LOG2 >= AW) begin : g_bad_gran
      $error("dfc_bkpt_match: GRAN_LOG2 must lie in [0, AW-1]");
   end

   logic addr_eq;

   if (GRAN_LOG2 == 0) begin : g_exact
      assign addr_eq = (ea == bkpt_ea);
   end else begin : g_block
      logic [CMP_W-1:0] ea_blk;
      logic [CMP_W-1:0] bk_blk;
      assign ea_blk  = ea[AW-1:GRAN_LOG2];
      assign bk_blk  = bkpt_ea[AW-1:GRAN_LOG2];
      assign addr_eq = (ea_blk == bk_blk);
   end

   logic armed;
   assign armed = (is_load & rd_en) | (is_store & wr_en);
   assign hit   = armed & addr_eq;

   always_comb begin
      assert_bkpt_dir_R6: assert (!(hit && !is_load && !is_store));
   end
endmodule

// File: rtl/dfc_cond.sv
module dfc_cond
   import dfc_pkg::*;
(
   input  logic [1:0] acc_kind,
   input  logic       acc_fp,
   input  logic       seg_direct_store,
   input  logic       xlate_miss,
   input  logic       walk_page_fault,
   input  logic       prot_violation,
   input  logic       bkpt_hit,
   output logic       is_load,
   output logic       is_store,
   output cause_t     raw_cause,
   output logic       fp_dseg
);
   acc_kind_e kind;
   logic      active;
   logic      ld_or_st;

   assign kind     = acc_kind_e'(acc_kind);
   assign is_load  = (kind == ACC_LOAD);
   assign is_store = (kind == ACC_STORE);
   assign active   = (kind != ACC_NONE);
   assign ld_or_st = is_load | is_store;

   always_comb begin
      raw_cause         = '0;
      raw_cause[C_PAGE] = active & xlate_miss & walk_page_fault;
      raw_cause[C_PROT] = active & ~xlate_miss & prot_violation;
      raw_cause[C_DSEG] = ld_or_st & seg_direct_store;
      raw_cause[C_BKPT] = bkpt_hit;
   end

   assign fp_dseg = acc_fp & raw_cause[C_DSEG];

   always_comb begin
      assert_idle_quiet_R1: assert (!(kind == ACC_NONE && bkpt_hit));
   end
endmodule

// File: rtl/dfc_out_stage.sv
module dfc_out_stage
   import dfc_pkg::*;
#(
   parameter int             AW         = 32,
   parameter int             VEC_W      = 12,
   parameter logic [VEC_W-1:0] VEC_OFFSET = 12'h300,
   parameter bit             PIPE       = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raise,
   input  cause_t           cause_in,
   input  logic             veto_in,
   input  logic [AW-1:0]    ea_in,
   output logic             fault_req,
   output logic [VEC_W-1:0] fault_vec,
   output cause_t           fault_cause,
   output logic [AW-1:0]    fault_ea,
   output logic             align_veto
);
   logic [AW-1:0] ea_q;

   if (PIPE) begin : g_reg
      logic   req_q;
      cause_t cause_q;
      logic   veto_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            req_q   <= 1'b0;
            cause_q <= '0;
            veto_q  <= 1'b0;
            ea_q    <= '0;
         end else begin
            req_q   <= raise;
            cause_q <= raise ? cause_in : '0;
            veto_q  <= raise & veto_in;
            if (raise) ea_q <= ea_in;
         end
      end

      assign fault_req   = req_q;
      assign fault_cause = cause_q;
      assign align_veto  = veto_q;
      assign fault_ea    = ea_q;
   end else begin : g_comb
      always_ff @(posedge clk) begin
         if (!rst_n)     ea_q <= '0;
         else if (raise) ea_q <= ea_in;
      end

      assign fault_req   = raise;
      assign fault_cause = raise ? cause_in : '0;
      assign align_veto  = raise & veto_in;
      assign fault_ea    = raise ? ea_in : ea_q;
   end

   assign fault_vec = fault_req ? VEC_OFFSET : '0;
endmodule

// File: rtl/dacc_fault_unit.sv
module dacc_fault_unit
   import dfc_pkg::*;
#(
   parameter int             AW         = 32,
   parameter int             GRAN_LOG2  = 3,
   parameter int             VEC_W      = 12,
   parameter logic [VEC_W-1:0] VEC_OFFSET = 12'h300,
   parameter bit             PIPE       = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       acc_kind,
   input  logic             acc_fp,
   input  logic [AW-1:0]    acc_ea,
   input  logic             seg_direct_store,
   input  logic             xlate_miss,
   input  logic             walk_page_fault,
   input  logic             prot_violation,
   input  logic [AW-1:0]    bkpt_ea,
   input  logic             bkpt_rd_en,
   input  logic             bkpt_wr_en,
   input  logic             hipri_pending,
   output logic             fault_req,
   output logic [VEC_W-1:0] fault_vec,
   output logic [3:0]       fault_cause,
   output logic [AW-1:0]    fault_ea,
   output logic             align_veto
);
   if (AW < 8) begin : g_bad_aw
      $error("dacc_fault_unit: AW must be at least 8");
   end
   if (VEC_W < 12) begin : g_bad_vw
      $error("dacc_fault_unit: VEC_W too narrow for the vector offset");
   end

   logic   is_load;
   logic   is_store;
   logic   bkpt_hit;
   logic   fp_dseg;
   logic   raise;
   cause_t raw_cause;
   cause_t cause_o;

   dfc_bkpt_match #(.AW(AW), .GRAN_LOG2(GRAN_LOG2)) u_bkpt (
      .ea       (acc_ea),
      .bkpt_ea  (bkpt_ea),
      .is_load  (is_load),
      .is_store (is_store),
      .rd_en    (bkpt_rd_en),
      .wr_en    (bkpt_wr_en),
      .hit      (bkpt_hit)
   );

   dfc_cond u_cond (
      .acc_kind         (acc_kind),
      .acc_fp           (acc_fp),
      .seg_direct_store (seg_direct_store),
      .xlate_miss       (xlate_miss),
      .walk_page_fault  (walk_page_fault),
      .prot_violation   (prot_violation),
      .bkpt_hit         (bkpt_hit),
      .is_load          (is_load),
      .is_store         (is_store),
      .raw_cause        (raw_cause),
      .fp_dseg          (fp_dseg)
   );

   assign raise = (|raw_cause) & ~hipri_pending;

   dfc_out_stage #(
      .AW(AW), .VEC_W(VEC_W), .VEC_OFFSET(VEC_OFFSET), .PIPE(PIPE)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .raise       (raise),
      .cause_in    (raw_cause),
      .veto_in     (fp_dseg),
      .ea_in       (acc_ea),
      .fault_req   (fault_req),
      .fault_vec   (fault_vec),
      .fault_cause (cause_o),
      .fault_ea    (fault_ea),
      .align_veto  (align_veto)
   );

   assign fault_cause = cause_o;

   if (PIPE) begin : g_chk
      assert_no_fault_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
         fault_req |-> $past(acc_kind) != 2'b11);
      assert_page_needs_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
         fault_cause[0] |-> $past(xlate_miss && walk_page_fault));
      assert_prot_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
         fault_cause[1] |-> $past(!xlate_miss && prot_violation));
      assert_dseg_ldst_R4: assert property (@(posedge clk) disable iff (!rst_n)
         fault_cause[2] |-> $past(seg_direct_store && !acc_kind[1]));
      assert_veto_fp_R5: assert property (@(posedge clk) disable iff (!rst_n)
         align_veto |-> (fault_cause[2] && $past(acc_fp)));
      assert_bkpt_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
         fault_cause[3] |-> $past(acc_ea[AW-1:GRAN_LOG2] == bkpt_ea[AW-1:GRAN_LOG2]));
      assert_hipri_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $past(hipri_pending) |-> !fault_req);
      assert_req_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
         fault_req |-> (fault_cause != '0 && fault_vec == VEC_OFFSET));
      assert_ea_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
         fault_req |-> fault_ea == $past(acc_ea));
      assert_ea_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !fault_req |-> $stable(fault_ea));
   end
endmodule

// File: tb/sim_dacc_fault_unit.sv
module sim_dacc_fault_unit;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [1:0]    acc_kind;
   logic          acc_fp;
   logic [AW-1:0] acc_ea;
   logic          seg_direct_store;
   logic          xlate_miss;
   logic          walk_page_fault;
   logic          prot_violation;
   logic [AW-1:0] bkpt_ea;
   logic          bkpt_rd_en;
   logic          bkpt_wr_en;
   logic          hipri_pending;
   logic          fault_req;
   logic [11:0]   fault_vec;
   logic [3:0]    fault_cause;
   logic [AW-1:0] fault_ea;
   logic          align_veto;

   int n_chk  = 0;
   int n_fail = 0;
   logic [AW-1:0] exp_ea = '0;

   always #10ns clk = ~clk;

   dacc_fault_unit u0 (
      .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .acc_fp(acc_fp),
      .acc_ea(acc_ea), .seg_direct_store(seg_direct_store),
      .xlate_miss(xlate_miss), .walk_page_fault(walk_page_fault),
      .prot_violation(prot_violation), .bkpt_ea(bkpt_ea),
      .bkpt_rd_en(bkpt_rd_en), .bkpt_wr_en(bkpt_wr_en),
      .hipri_pending(hipri_pending), .fault_req(fault_req),
      .fault_vec(fault_vec), .fault_cause(fault_cause),
      .fault_ea(fault_ea), .align_veto(align_veto)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      rst_n = 1'b0; acc_kind = 2'b11; acc_fp = 0; acc_ea = '0;
      seg_direct_store = 0; xlate_miss = 0; walk_page_fault = 0;
      prot_violation = 0; bkpt_ea = 32'hA5A5_5A58; bkpt_rd_en = 0;
      bkpt_wr_en = 0; hipri_pending = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state
      check("R10", "fault_req",   fault_req,   0);
      check("R10", "fault_cause", fault_cause, 0);
      check("R10", "fault_vec",   fault_vec,   0);
      check("R10", "align_veto",  align_veto,  0);
      check("R10", "fault_ea",    fault_ea,    0);
      rst_n = 1'b1;

      for (int i = 0; i < 4 * 256 * 3; i++) begin
         int  k     = i % 4;
         int  f     = (i / 4) % 256;
         int  m     = i / 1024;
         bit  fp    = f[0], ds = f[1], ms = f[2], pf = f[3];
         bit  pv    = f[4], rd = f[5], wr = f[6], hi = f[7];
         bit  ld    = (k == 0), st = (k == 1), act = (k != 3);
         bit  dw_eq;
         logic [3:0] raw;
         bit  rz;
         logic [AW-1:0] ea;
         string req;

         case (m)
            0: ea = bkpt_ea | AW'(i & 7);
            1: ea = bkpt_ea ^ 32'h0000_0008;
            default: ea = bkpt_ea ^ 32'h8000_0000 ^ AW'(i);
         endcase
         dw_eq = (ea[AW-1:3] == bkpt_ea[AW-1:3]);

         acc_kind = 2'(k); acc_fp = fp; acc_ea = ea; seg_direct_store = ds;
         xlate_miss = ms; walk_page_fault = pf; prot_violation = pv;
         bkpt_rd_en = rd; bkpt_wr_en = wr; hipri_pending = hi;

         raw[0] = act & ms & pf;                    // R2
         raw[1] = act & ~ms & pv;                   // R3
         raw[2] = (ld | st) & ds;                   // R4
         raw[3] = ((ld & rd) | (st & wr)) & dw_eq;  // R6
         rz = (|raw) & ~hi;
         if (rz) exp_ea = ea;

         if (hi)          req = "R7";
         else if (!act)   req = "R1";
         else if (raw[3]) req = "R6";
         else if (raw[2]) req = "R4";
         else if (raw[1]) req = "R3";
         else             req = "R2";

         @(posedge clk);
         @(negedge clk);
         check(req,  "fault_req",   fault_req,   rz);
         check(req,  "fault_cause", fault_cause, rz ? raw : 4'h0);
         check("R8", "fault_vec",   fault_vec,   rz ? 12'h300 : 12'h0);
         check("R9", "fault_ea",    fault_ea,    exp_ea);
         check("R5", "align_veto",  align_veto,  rz & fp & raw[2]);
      end

      // R8: single pulse - an idle cycle after a fault clears the request
      acc_kind = 2'b00; seg_direct_store = 1; hipri_pending = 0; acc_ea = 32'h0000_1000;
      @(posedge clk); @(negedge clk);
      check("R8", "fault_req first", fault_req, 1);
      acc_kind = 2'b11;
      @(posedge clk); @(negedge clk);
      check("R8", "fault_req after", fault_req, 0);
      check("R9", "fault_ea held",   fault_ea,  32'h0000_1000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule